// File: doc/BRIEF.md
# Supply-Fail and Pushbutton Reset Sequencer

This block produces the reset for a processor from two digital inputs: the output of an external supply-voltage comparator, and an active-low pushbutton line that is already synchronised to the clock. A drop in the supply must persist for a short qualification window before it counts. This rejects noise spikes. Once it counts, reset asserts within a few microseconds.

Reset is then held. Only after a fixed stretch with no cause for reset is it released. The pushbutton is debounced inside the block, and its hold stretch starts when the button is let go, not when it is pressed. A fresh cause during the hold starts the stretch over.

The clock frequency is a parameter. The hold stretch (in microseconds) and the glitch window (in nanoseconds) are converted into cycle counts from it. The debounce window is given in cycles. At the defaults (50 MHz, 205 ms hold, 3 µs filter), the hold lies in the 130–285 ms band. A qualified drop reaches the reset outputs about 3 µs after it starts, and any drop shorter than 2 µs is ignored. An asynchronous power-on clear forces reset active, so the hold also applies at power-up.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n_i` is 0, `rst_o` is 1 and `rst_n_o` is 0 at once, without waiting for a clock edge.
- R2: `rst_n_o` is at all times the inverse of `rst_o`.
- R3: When `supply_ok_i` (1 = in tolerance) is sampled 0 on FILT_CYC consecutive rising edges, `rst_o` is 1 after the next edge, that is, FILT_CYC+1 edges after the first low sample.
- R4: A run of fewer than FILT_CYC consecutive low samples on `supply_ok_i` does not cause a reset.
- R5: After the last edge at which a qualified supply fault or a debounced press was present, `rst_o` stays 1 for exactly HOLD_CYC further edges and then returns to 0.
- R6: `btn_n_i` (0 = pressed) changes its debounced level only after DEB_CYC consecutive samples at the new level. Shorter bounces have no effect on the reset.
- R7: `rst_o` is 1 from the edge after a press is accepted. The hold stretch for a button event counts from the accepted release.
- R8: A qualified supply fault or an accepted press during the hold stretch restarts the stretch from zero.
- R9: After `por_n_i` is released, with the supply good and the button released, `rst_o` stays 1 for exactly HOLD_CYC edges.
- R10: A supply fault lasting any length of time keeps reset asserted for its whole duration. The low-run counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at CLK_HZ |
| por_n_i | input | 1 | Asynchronous power-on clear, active low |
| supply_ok_i | input | 1 | Supply comparator output, 1 = in tolerance |
| btn_n_i | input | 1 | Synchronised pushbutton, 0 = pressed |
| rst_o | output | 1 | Reset, active high |
| rst_n_o | output | 1 | Reset, active low |

## Verification
The bench builds the block with CLK_HZ = 1 MHz, HOLD_US = 40, FILT_NS = 3000 and DEB_CYC = 4. This gives a 40-cycle hold, a 3-cycle glitch window and a 4-cycle debounce. With these values, every hold can run to completion many times in a short run. Glitches one cycle short of the window, and one cycle long enough, can be placed exactly. Restarts in the middle of a hold are easy to provoke with random bursts of supply faults and bouncing presses.

// File: rtl/rsup_pkg.sv
`timescale 1ns/1ps
package rsup_pkg;

    // Converts a duration (amount / per_s seconds) at hz into clock cycles, at least one.
    function automatic int unsigned to_cycles(input longint unsigned hz,
                                              input longint unsigned amount,
                                              input longint unsigned per_s);
        longint unsigned c;
        c = (hz * amount) / per_s;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/rsup_glitch_filter.sv
`timescale 1ns/1ps
module rsup_glitch_filter #(
    parameter int unsigned LEN = 3
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic ok_i,
    output logic fail_o
);
    localparam int unsigned CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          fail;
    } flt_t;

    flt_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ok_i) begin
            s_d.run  = '0;
            s_d.fail = 1'b0;
        end else begin
            if (s_q.run != CW'(LEN)) s_d.run = s_q.run + 1'b1;
            s_d.fail = (s_q.run >= CW'(LEN - 1));
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) s_q <= '0;
        else          s_q <= s_d;
    end

    assign fail_o = s_q.fail;
endmodule

// File: rtl/rsup_debounce.sv
`timescale 1ns/1ps
module rsup_debounce #(
    parameter int unsigned WIN = 4
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic btn_n_i,
    output logic level_o,
    output logic pressed_o
);
    localparam int unsigned DW = $clog2(WIN + 1);

    typedef struct packed {
        logic          level;
        logic [DW-1:0] cnt;
    } deb_t;

    deb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (btn_n_i == s_q.level) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == DW'(WIN - 1)) begin
            s_d.level = btn_n_i;
            s_d.cnt   = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) s_q <= '{level: 1'b1, cnt: '0};
        else          s_q <= s_d;
    end

    assign level_o   = s_q.level;
    assign pressed_o = ~s_q.level;
endmodule

// File: rtl/rsup_hold_timer.sv
`timescale 1ns/1ps
module rsup_hold_timer #(
    parameter int unsigned HOLD = 40,
    parameter int unsigned HW   = $clog2(HOLD + 1)
) (
    input  logic          clk_i,
    input  logic          por_n_i,
    input  logic          trig_i,
    output logic          rst_o,
    output logic [HW-1:0] cnt_o
);
    typedef struct packed {
        logic          rst;
        logic [HW-1:0] cnt;
    } hold_t;

    hold_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (trig_i) begin
            s_d.rst = 1'b1;
            s_d.cnt = '0;
        end else if (s_q.rst) begin
            if (s_q.cnt == HW'(HOLD - 1)) s_d.rst = 1'b0;
            else                          s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) s_q <= '{rst: 1'b1, cnt: '0};
        else          s_q <= s_d;
    end

    assign rst_o = s_q.rst;
    assign cnt_o = s_q.cnt;
endmodule

// File: rtl/rst_supervisor.sv
`timescale 1ns/1ps
module rst_supervisor #(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned HOLD_US = 205_000,
    parameter int unsigned FILT_NS = 3_000,
    parameter int unsigned DEB_CYC = 50_000
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic supply_ok_i,
    input  logic btn_n_i,
    output logic rst_o,
    output logic rst_n_o
);
    localparam int unsigned HOLD_CYC = rsup_pkg::to_cycles(CLK_HZ, HOLD_US, 1_000_000);
    localparam int unsigned FILT_CYC = rsup_pkg::to_cycles(CLK_HZ, FILT_NS, 1_000_000_000);
    localparam int unsigned DEB_WIN  = (DEB_CYC < 1) ? 1 : DEB_CYC;
    localparam int unsigned HOLD_W   = $clog2(HOLD_CYC + 1);

    logic              sup_fail;
    logic              btn_level;
    logic              btn_pressed;
    logic              hold_rst;
    logic [HOLD_W-1:0] hold_cnt;

    rsup_glitch_filter #(.LEN(FILT_CYC)) u_filt (
        .clk_i   (clk_i),
        .por_n_i (por_n_i),
        .ok_i    (supply_ok_i),
        .fail_o  (sup_fail)
    );

    rsup_debounce #(.WIN(DEB_WIN)) u_deb (
        .clk_i     (clk_i),
        .por_n_i   (por_n_i),
        .btn_n_i   (btn_n_i),
        .level_o   (btn_level),
        .pressed_o (btn_pressed)
    );

    rsup_hold_timer #(.HOLD(HOLD_CYC), .HW(HOLD_W)) u_hold (
        .clk_i   (clk_i),
        .por_n_i (por_n_i),
        .trig_i  (sup_fail | btn_pressed),
        .rst_o   (hold_rst),
        .cnt_o   (hold_cnt)
    );

    assign rst_o   = hold_rst;
    assign rst_n_o = ~hold_rst;
endmodule

// File: rtl/rst_supervisor_chk.sv
`timescale 1ns/1ps
module rst_supervisor_chk #(
    parameter int unsigned CW = 1
) (
    input logic          clk_i,
    input logic          por_n_i,
    input logic          supply_ok_i,
    input logic          btn_n_i,
    input logic          fail_i,
    input logic          pressed_i,
    input logic          btn_level_i,
    input logic [CW-1:0] hold_cnt_i,
    input logic          rst_i,
    input logic          rst_n_i
);
    // R3
    fail_to_rst_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        fail_i |=> rst_i);

    // R4
    fail_needs_low_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(fail_i) |-> $past(!supply_ok_i));

    // R7
    press_to_rst_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        pressed_i |=> rst_i);

    // R5
    release_quiet_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $fell(rst_i) |-> $past(!fail_i && !pressed_i));

    // R8
    restart_clear_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (fail_i || pressed_i) |=> (hold_cnt_i == '0));

    // R6
    level_follows_pin_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !$stable(btn_level_i) |-> (btn_level_i == $past(btn_n_i)));

    // R2
    outputs_opposite_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(rst_i) |-> $fell(rst_n_i));
endmodule

bind rst_supervisor rst_supervisor_chk #(.CW(HOLD_W)) chk_i (
    .clk_i       (clk_i),
    .por_n_i     (por_n_i),
    .supply_ok_i (supply_ok_i),
    .btn_n_i     (btn_n_i),
    .fail_i      (sup_fail),
    .pressed_i   (btn_pressed),
    .btn_level_i (btn_level),
    .hold_cnt_i  (hold_cnt),
    .rst_i       (rst_o),
    .rst_n_i     (rst_n_o)
);

// File: tb/rst_supervisor_tb_top.sv
`timescale 1ns/1ps
module rst_supervisor_tb_top;
    localparam int TB_HOLD = 40;
    localparam int TB_FILT = 3;
    localparam int TB_DEB  = 4;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic supply_ok = 1'b1;
    logic btn_n = 1'b1;
    logic rst_o, rst_n_o;

    int nchk = 0;
    int nerr = 0;
    string tag_cur = "R1";

    always #2.5 clk = ~clk;

    rst_supervisor #(
        .CLK_HZ(1_000_000), .HOLD_US(40), .FILT_NS(3000), .DEB_CYC(TB_DEB)
    ) dut_i (
        .clk_i(clk), .por_n_i(por_n), .supply_ok_i(supply_ok), .btn_n_i(btn_n),
        .rst_o(rst_o), .rst_n_o(rst_n_o)
    );

    // Reference model built from the requirements
    bit m_rst = 1'b1, m_fail = 1'b0, m_level = 1'b1;
    int m_quiet = 0, m_run = 0, m_drun = 0;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_rst = 1'b1; m_quiet = 0; m_run = 0; m_fail = 1'b0; m_level = 1'b1; m_drun = 0;
        end else begin
            if (m_fail || !m_level) begin
                m_rst = 1'b1; m_quiet = 0;
            end else if (m_rst) begin
                m_quiet++;
                if (m_quiet >= TB_HOLD) m_rst = 1'b0;
            end
            if (supply_ok) begin
                m_run = 0; m_fail = 1'b0;
            end else begin
                if (m_run < TB_FILT) m_run++;
                m_fail = (m_run >= TB_FILT);
            end
            if (btn_n == m_level) m_drun = 0;
            else begin
                m_drun++;
                if (m_drun >= TB_DEB) begin m_level = btn_n; m_drun = 0; end
            end
        end
    end

    function automatic int supply_latency();
        return TB_FILT + 1;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag_cur, rst_o, m_rst);
            check("R2", rst_n_o, ~m_rst);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1 / R9: power-on
        tag_cur = "R1";
        tick(3);
        check("R1", rst_o, 1'b1);
        check("R1", rst_n_o, 1'b0);
        por_n = 1'b1;
        tag_cur = "R9";
        tick(TB_HOLD - 1);
        check("R9", rst_o, 1'b1);
        tick(1);
        check("R9", rst_o, 1'b0);
        tick(5);

        // R4: glitch one sample short
        tag_cur = "R4";
        supply_ok = 1'b0; tick(TB_FILT - 1); supply_ok = 1'b1;
        tick(10);
        check("R4", rst_o, 1'b0);

        // R3 / R10 / R5
        tag_cur = "R3";
        supply_ok = 1'b0;
        tick(supply_latency() - 1);
        check("R3", rst_o, 1'b0);
        tick(1);
        check("R3", rst_o, 1'b1);
        tag_cur = "R10";
        tick(20);
        check("R10", rst_o, 1'b1);
        supply_ok = 1'b1;
        tag_cur = "R5";
        tick(TB_HOLD);
        check("R5", rst_o, 1'b1);
        tick(1);
        check("R5", rst_o, 1'b0);
        tick(5);

        // R6: bounce shorter than the window
        tag_cur = "R6";
        btn_n = 1'b0; tick(TB_DEB - 1); btn_n = 1'b1;
        tick(10);
        check("R6", rst_o, 1'b0);

        // R7: press, hold from release
        tag_cur = "R7";
        btn_n = 1'b0;
        tick(TB_DEB);
        check("R7", rst_o, 1'b0);
        tick(1);
        check("R7", rst_o, 1'b1);
        tick(30);
        btn_n = 1'b1;
        tick(TB_DEB + TB_HOLD - 1);
        check("R7", rst_o, 1'b1);
        tick(1);
        check("R7", rst_o, 1'b0);
        tick(5);

        // R8: new fault mid-hold restarts the stretch
        tag_cur = "R8";
        supply_ok = 1'b0; tick(TB_FILT); supply_ok = 1'b1;
        tick(10);
        supply_ok = 1'b0; tick(TB_FILT); supply_ok = 1'b1;
        tick(TB_HOLD);
        check("R8", rst_o, 1'b1);
        tick(1);
        check("R8", rst_o, 1'b0);
        tick(5);

        // R1: asynchronous clear mid-operation
        por_n = 1'b0;
        #1;
        check("R1", rst_o, 1'b1);
        check("R1", rst_n_o, 1'b0);
        tag_cur = "R1";
        tick(2);
        por_n = 1'b1;
        tag_cur = "R9";
        tick(TB_HOLD - 1);
        check("R9", rst_o, 1'b1);
        tick(1);
        check("R9", rst_o, 1'b0);

        // Random mix, compared every cycle against the model (R5, R8)
        tag_cur = "R5";
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom % 8);
            case (sel)
                0: begin supply_ok = 1'b0; tick(1 + int'($urandom % (TB_FILT + 3))); supply_ok = 1'b1; end
                1: begin btn_n = 1'b0; tick(1 + int'($urandom % (TB_DEB + 4))); btn_n = 1'b1; end
                2: begin
                    supply_ok = 1'b0; btn_n = 1'b0;
                    tick(1 + int'($urandom % (TB_DEB + 4)));
                    supply_ok = 1'b1; btn_n = 1'b1;
                end
                default: tick(1 + int'($urandom % (TB_HOLD + 20)));
            endcase
        end
        tick(TB_HOLD + 5);
        check("R5", rst_o, 1'b0);

        summary();
        $finish;
    end
endmodule